// File: doc/BRIEF.md
# Five-Neighbour Pixel Predictor

This block accepts a raster-ordered stream of grey pixels and turns each one into a signed prediction residual. Each pixel is estimated from five neighbours: the three pixels of the row above (up-left, up, up-right), the pixel to its left, and the pixel to its right. The estimate is the mean of those five values, rounded to the nearest integer. The residual is the pixel minus that estimate. The top-left and bottom-right pixels of every image are not predicted. They are sent out unchanged, with a flag set, so that a decoder can start from them.

A single line buffer holds the previous row. A short window of registers holds the two most recent pixels of the current row and of the row above. The right-hand neighbour is the next input sample, so every result leaves one accepted sample late. After the last pixel of a row, the block spends one cycle emitting the final result of that row. In that cycle the right-hand neighbour and the up-right neighbour are taken as zero, and no input is accepted. Images follow each other without a break: the row counter wraps after the last row.

The control is a two-state machine:
- `ST_RUN` accepts pixels.
- `ST_FLUSH` drains the last column of a row.

It has two transitions:
- *end-of-row*: `ST_RUN` to `ST_FLUSH`, when the last column is accepted.
- *resume*: `ST_FLUSH` to `ST_RUN`, unconditionally after one cycle. This transition also advances or wraps the row.

Top module: `fnp_predictor`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: For a predicted pixel, the prediction is the sum of its up-left, up, up-right, left and right neighbours divided by 5 and rounded to the nearest integer. `out_res` is the pixel minus the prediction, as a 9-bit two's-complement value, and `out_bypass` is 0.
- R3: A neighbour outside the image counts as 0. This covers the row above row 0, the column left of column 0, and the column right of the last column.
- R4: The top-left pixel of each image is output with `out_bypass` = 1 and `out_res` equal to the pixel, zero-extended.
- R5: The bottom-right pixel of each image is output the same way as the top-left pixel. No other pixel has `out_bypass` = 1.
- R6: In the cycle after the last pixel of a row is accepted, `in_ready` is 0. It is 1 again in the cycle after that.
- R7: The following timing rules hold:
  - One result is produced per pixel, in raster order.
  - The result for column c, below the last column, appears in the cycle after column c+1 is accepted.
  - The result for the last column appears in the cycle after the flush cycle.
  - Accepting column 0 gives no result in the next cycle.
- R8: Idle cycles with `in_valid` = 0 between pixels do not change any result.
- R9: After the last row, the next accepted pixel is row 0 of a new image. That row sees zeros above it, whatever the previous image held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle (low during the flush cycle) |
| in_pix | input | PIX_W | Input grey pixel, unsigned |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | PIX_W+1 | Residual in two's complement, or the raw pixel when bypassed |
| out_bypass | output | 1 | Result is an unpredicted corner pixel |

## Verification
The assertions check several behaviours on every cycle:
- The end-of-row transition lowers `in_ready`.
- The flush lasts exactly one cycle and always yields a result.
- Accepting column 0 never yields a result.
- The constant multiply-and-shift divider stays within half a unit of the exact fifth of the neighbour sum.

Only the bench scenarios can show the rest, because it depends on the values of whole images:
- the residual values, including the zero neighbours at the borders;
- which two pixels are flagged;
- the exact cycle of each result relative to the acceptances;
- that idle gaps leave the results unchanged;
- that the second of two back-to-back images ignores the first.

// File: rtl/fnp_pkg.sv
package fnp_pkg;

    // control states of the predictor
    typedef enum logic {
        ST_RUN   = 1'b0,   // accepting pixels
        ST_FLUSH = 1'b1    // emitting the last column of a row
    } fnp_state_e;

endpackage

// File: rtl/fnp_linebuf.sv
// One-row store: written at the column being accepted, read at the same
// column before the write lands, so the read returns the row above.
module fnp_linebuf #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fnp_calc.sv
// Five-neighbour sum, rounded divide by five, residual formation.
module fnp_calc #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]        up_left,
    input  logic [PIX_W-1:0]        up_mid,
    input  logic [PIX_W-1:0]        up_right,
    input  logic [PIX_W-1:0]        left,
    input  logic [PIX_W-1:0]        right,
    input  logic [PIX_W-1:0]        centre,
    input  logic                    bypass,
    output logic [PIX_W+2:0]        sum,
    output logic [PIX_W-1:0]        pred,
    output logic signed [PIX_W:0]   res
);

    localparam int SUM_W  = PIX_W + 3;
    // three guard bits keep the reciprocal error below 0.1 of a unit
    localparam int SH     = SUM_W + 3;
    localparam int MULT   = ((1 << SH) + 4) / 5;
    localparam int HALF   = 1 << (SH - 1);
    localparam int PROD_W = SUM_W + SH;

    assign sum = SUM_W'(up_left) + SUM_W'(up_mid) + SUM_W'(up_right)
               + SUM_W'(left) + SUM_W'(right);

    assign pred = PIX_W'((PROD_W'(sum) * PROD_W'(MULT) + PROD_W'(HALF)) >> SH);

    assign res = bypass ? $signed({1'b0, centre})
                        : $signed({1'b0, centre}) - $signed({1'b0, pred});

endmodule

// File: rtl/fnp_predictor.sv
module fnp_predictor
    import fnp_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PIX_W-1:0]      in_pix,
    output logic                  out_valid,
    output logic [PIX_W:0]        out_res,
    output logic                  out_bypass
);

    localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int SUM_W = PIX_W + 3;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);
    localparam logic ONE_COL = (IMG_W == 1);

    fnp_state_e          state;
    logic [COL_W-1:0]    col;
    logic [ROW_W-1:0]    row;

    logic [PIX_W-1:0]    win_mid, win_left, up_mid, up_left;
    logic [PIX_W-1:0]    up_raw, up_new;
    logic                accept, flushing, emit, at_first, corner;
    logic [PIX_W-1:0]    calc_ur, calc_rt, calc_pred;
    logic [SUM_W-1:0]    calc_sum;
    logic signed [PIX_W:0] calc_res;

    assign flushing = (state == ST_FLUSH);
    assign in_ready = !flushing;
    assign accept   = in_valid && in_ready;

    // row 0 has nothing above it, whatever the buffer still holds
    assign up_new   = (row == '0) ? '0 : up_raw;

    // a result is due when the right neighbour arrives, or in the flush
    assign emit     = flushing || (accept && (col != '0));
    assign at_first = flushing ? ONE_COL : (col == COL_W'(1));
    assign corner   = ((row == '0) && at_first) || (flushing && (row == LAST_ROW));

    // beyond the last column both right-hand neighbours are zero
    assign calc_ur  = flushing ? '0 : up_new;
    assign calc_rt  = flushing ? '0 : in_pix;

    fnp_linebuf #(
        .DEPTH (IMG_W),
        .DW    (PIX_W),
        .AW    (COL_W)
    ) u_line (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (col),
        .wr_data (in_pix),
        .rd_addr (col),
        .rd_data (up_raw)
    );

    fnp_calc #(
        .PIX_W (PIX_W)
    ) u_calc (
        .up_left  (up_left),
        .up_mid   (up_mid),
        .up_right (calc_ur),
        .left     (win_left),
        .right    (calc_rt),
        .centre   (win_mid),
        .bypass   (corner),
        .sum      (calc_sum),
        .pred     (calc_pred),
        .res      (calc_res)
    );

    // state register with column and row position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
            col   <= '0;
            row   <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (accept) begin
                        if (col == LAST_COL) begin
                            col   <= '0;
                            state <= ST_FLUSH;      // end-of-row
                        end else begin
                            col <= col + 1'b1;
                        end
                    end
                end
                ST_FLUSH: begin
                    row   <= (row == LAST_ROW) ? '0 : row + 1'b1;
                    state <= ST_RUN;                // resume
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // neighbour window, shifted on every accepted pixel
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_left <= '0;
            win_mid  <= '0;
            up_left  <= '0;
            up_mid   <= '0;
        end else if (accept) begin
            win_left <= (col == '0) ? '0 : win_mid;
            up_left  <= (col == '0) ? '0 : up_mid;
            win_mid  <= in_pix;
            up_mid   <= up_new;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_res    <= '0;
            out_bypass <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_res    <= calc_res;
                out_bypass <= corner;
            end
        end
    end

    // R6: taking the last column of a row leads into the flush cycle
    p_flush_after_eol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (col == LAST_COL)) |=> !in_ready);

    // R6: the flush never lasts more than one cycle
    p_flush_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R7: the flush always produces the last column's result
    p_flush_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> out_valid);

    // R7: accepting the first column of a row produces nothing yet
    p_row_start_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (col == '0)) |=> !out_valid);

    // R2: the constant-multiply divider lands within half a unit of sum/5
    p_div_round_r2: assert property (@(posedge clk) disable iff (!rst_n)
        emit |-> ((int'(calc_pred) * 5 <= int'(calc_sum) + 2) &&
                  (int'(calc_pred) * 5 + 2 >= int'(calc_sum))));

endmodule

// File: tb/fnp_predictor_tb.sv
`timescale 1ns/1ps
module fnp_predictor_tb;

    localparam int W    = 8;
    localparam int H    = 6;
    localparam int NPIX = W * H;
    localparam int MAXP = 2 * NPIX;
    localparam int OBUF = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pix = 8'd0;
    logic       out_valid;
    logic [8:0] out_res;
    logic       out_bypass;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_out  = 0;
    bit done   = 1'b0;

    logic [7:0] img      [MAXP];
    int         acc_edge [MAXP];
    int         o_res    [OBUF];
    bit         o_byp    [OBUF];
    int         o_cyc    [OBUF];

    fnp_predictor #(
        .PIX_W (8),
        .IMG_W (W),
        .IMG_H (H)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_pix     (in_pix),
        .out_valid  (out_valid),
        .out_res    (out_res),
        .out_bypass (out_bypass)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // record every result together with the edge that produced it
    always @(negedge clk) begin
        if (rst_n && out_valid && n_out < OBUF) begin
            o_res[n_out] = int'($signed(out_res));
            o_byp[n_out] = out_bypass;
            o_cyc[n_out] = cyc;
            n_out = n_out + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int nb(input int ib, input int r, input int c);
        if (r < 0 || c < 0 || r >= H || c >= W) return 0;
        return int'(img[ib + r * W + c]);
    endfunction

    // drive one image; every call starts and ends at a falling edge
    task automatic send_image(input int ib, input int maxgap);
        for (int k = 0; k < NPIX; k++) begin
            int gap;
            gap = (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0;
            repeat (gap) @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_pix   = img[ib + k];
            acc_edge[ib + k] = cyc + 1;
            @(negedge clk);
            in_valid = 1'b0;
            if (k % W == W - 1) begin
                chk(in_ready == 1'b0, "R6", "ready low in flush", int'(in_ready), 0);
                @(negedge clk);
                chk(in_ready == 1'b1, "R6", "ready back after flush", int'(in_ready), 1);
            end
        end
    endtask

    task automatic check_image(input int ib, input int ob, input string over);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                int k, s, er, ecyc;
                bit eb;
                string req;
                k  = r * W + c;
                eb = (r == 0 && c == 0) || (r == H - 1 && c == W - 1);
                if (eb) begin
                    er  = int'(img[ib + k]);
                    req = (r == 0) ? "R4" : "R5";
                end else begin
                    s  = nb(ib, r - 1, c - 1) + nb(ib, r - 1, c) + nb(ib, r - 1, c + 1)
                       + nb(ib, r, c - 1) + nb(ib, r, c + 1);
                    er = int'(img[ib + k]) - (2 * s + 5) / 10;
                    req = (r == 0 || c == 0 || c == W - 1) ? "R3" : "R2";
                end
                if (over != "") req = over;
                chk(o_res[ob + k] == er, req, $sformatf("residual r%0d c%0d", r, c),
                    o_res[ob + k], er);
                chk(o_byp[ob + k] == eb, eb ? req : "R5",
                    $sformatf("bypass flag r%0d c%0d", r, c), int'(o_byp[ob + k]), int'(eb));
                ecyc = (c < W - 1) ? acc_edge[ib + k + 1] : acc_edge[ib + k] + 1;
                chk(o_cyc[ob + k] == ecyc, "R7", $sformatf("result edge r%0d c%0d", r, c),
                    o_cyc[ob + k], ecyc);
            end
        end
    endtask

    task automatic settle_and_count(input int ob, input int expect_n);
        repeat (4) @(negedge clk);
        chk(n_out - ob == expect_n, "R7", "result count", n_out - ob, expect_n);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_ramp;
        int ob;
        for (int k = 0; k < NPIX; k++) img[k] = 8'((k / W) * 20 + (k % W) * 10);
        ob = n_out;
        send_image(0, 0);
        settle_and_count(ob, NPIX);
        check_image(0, ob, "");
    endtask

    task automatic t_checker;
        int ob;
        for (int k = 0; k < NPIX; k++) img[k] = (((k / W) + (k % W)) % 2 == 1) ? 8'd255 : 8'd0;
        ob = n_out;
        send_image(0, 0);
        settle_and_count(ob, NPIX);
        check_image(0, ob, "");
    endtask

    task automatic t_flat_max;
        int ob;
        for (int k = 0; k < NPIX; k++) img[k] = 8'd255;
        ob = n_out;
        send_image(0, 0);
        settle_and_count(ob, NPIX);
        check_image(0, ob, "");
    endtask

    task automatic t_random_gaps;
        int ob;
        for (int k = 0; k < NPIX; k++) img[k] = 8'($urandom_range(0, 255));
        ob = n_out;
        send_image(0, 3);
        settle_and_count(ob, NPIX);
        check_image(0, ob, "R8");
    endtask

    task automatic t_two_images;
        int ob;
        for (int k = 0; k < MAXP; k++) img[k] = 8'($urandom_range(0, 255));
        ob = n_out;
        send_image(0, 0);
        send_image(NPIX, 0);
        settle_and_count(ob, MAXP);
        check_image(0, ob, "");
        check_image(NPIX, ob + NPIX, "R9");
    endtask

    initial begin
        t_reset();
        t_ramp();
        t_checker();
        t_flat_max();
        t_random_gaps();
        t_random_gaps();
        t_two_images();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule